// File: doc/BRIEF.md
# Presettable Synchronous Up-Counter with Dual Count Enables

This block is a binary up-counter whose register changes only on the rising clock edge. Each edge applies exactly one operation, chosen by a fixed order of precedence. An active-low clear has the highest priority. An active-low parallel load comes next. A count step follows, and a hold is the default. The count wraps from its all-ones value back to zero. The width is a parameter with a default of 4 bits, so the default counter runs modulo 16.

There are two count-enable inputs, a parallel enable and a trickle enable. Both must be high for the counter to step. Only the trickle enable reaches the terminal-count output. That output is a combinational decode of the all-ones state and the trickle enable.

Because of this split, several counters can form one wider counter with no extra gates. The terminal count of the lowest stage drives the parallel enable of each later stage. The trickle enable passes from stage to stage. The carry chain then has a full wrap period of the lowest stage to settle.

Top module: `presettable_counter`

## Requirements
- R1: When `clr_n` is low at a rising edge, `cnt` becomes 0 after that edge, whatever the values of `ld_n`, `din`, `en_par` and `en_trk`.
- R2: When `clr_n` is high and `ld_n` is low at a rising edge, `cnt` takes the value of `din` after that edge, and the enables have no effect.
- R3: When `clr_n`, `ld_n`, `en_par` and `en_trk` are all high at a rising edge, `cnt` increases by one after that edge.
- R4: A count step from the all-ones value (15 at the default width) gives 0.
- R5: When `clr_n` and `ld_n` are high and either `en_par` or `en_trk` is low at a rising edge, `cnt` keeps its value.
- R6: `tc` is 1 exactly when every bit of `cnt` is 1 and `en_trk` is 1. The value of `en_par` has no effect on `tc`.
- R7: `tc` follows a change of `en_trk` within the same clock cycle, with no edge in between.
- R8: A load of the all-ones value with `en_trk` high makes `tc` go high in the cycle after the load edge.
- R9: Pulses on `clr_n`, `ld_n` or `din` between rising edges leave the register unchanged. Only the values present at the edge count.
- R10: Two counters chained in lookahead form step through all 256 states of an 8-bit count and wrap from 255 to 0. In that chain, the low stage's `tc` drives the high stage's `en_par`, and the common enable drives both stages' `en_trk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register update happens on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| din | input | WIDTH | Parallel data loaded when `ld_n` is low |
| en_par | input | 1 | Parallel count enable; gates counting only |
| en_trk | input | 1 | Trickle count enable; gates counting and `tc` |
| cnt | output | WIDTH | Current count |
| tc | output | 1 | Terminal count: all ones AND `en_trk` |

## Verification
Every instance in the bench uses the default `WIDTH` of 4. At that width the whole 16-state wrap, including the 15-to-0 step, takes only a few cycles. Two such instances are chained in lookahead form. This reaches the 256-state, 8-bit wrap and the carry handoff between stages in a few hundred cycles, so every stage-to-stage carry is covered.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_STEP  = 2'd2,
        MODE_KEEP  = 2'd3
    } ctr_mode_e;
endpackage

// File: rtl/ctr_mode_sel.sv
module ctr_mode_sel
    import ctr_pkg::*;
(
    input  logic      clr_n,
    input  logic      ld_n,
    input  logic      en_par,
    input  logic      en_trk,
    output ctr_mode_e mode
);
    // Fixed precedence: clear, then load, then step, then keep.
    always_comb begin
        if (!clr_n)                 mode = MODE_CLEAR;
        else if (!ld_n)             mode = MODE_LOAD;
        else if (en_par && en_trk)  mode = MODE_STEP;
        else                        mode = MODE_KEEP;
    end
endmodule

// File: rtl/ctr_next.sv
module ctr_next
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  ctr_mode_e          mode,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   din,
    output logic [WIDTH-1:0]   nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (mode)
            MODE_CLEAR: nxt = '0;
            MODE_LOAD:  nxt = din;
            MODE_STEP:  nxt = cur + ONE;   // natural wrap modulo 2**WIDTH
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_tc_decode.sv
module ctr_tc_decode #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_trk,
    output logic             tc
);
    logic [WIDTH:0] chain;

    assign chain[0] = en_trk;
    for (genvar i = 0; i < WIDTH; i++) begin : g_and
        assign chain[i+1] = chain[i] & cur[i];
    end
    assign tc = chain[WIDTH];
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ld_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_par,
    input  logic             en_trk,
    output logic [WIDTH-1:0] cnt,
    output logic             tc
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] value;
    } state_t;

    state_t           state_d, state_q;
    ctr_mode_e        mode;
    logic [WIDTH-1:0] nxt_value;

    ctr_mode_sel u_mode (
        .clr_n  (clr_n),
        .ld_n   (ld_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .mode   (mode)
    );

    ctr_next #(.WIDTH(WIDTH)) u_next (
        .mode (mode),
        .cur  (state_q.value),
        .din  (din),
        .nxt  (nxt_value)
    );

    ctr_tc_decode #(.WIDTH(WIDTH)) u_tc (
        .cur    (state_q.value),
        .en_trk (en_trk),
        .tc     (tc)
    );

    always_comb begin
        state_d       = state_q;
        state_d.value = nxt_value;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign cnt = state_q.value;

    // Checks become active once a clear has defined the register.
    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        armed_q <= armed_q | ~clr_n;
    end

    assert_clear_R1: assert property (@(posedge clk) disable iff (!armed_q)
        !clr_n |=> cnt == '0);

    assert_load_R2: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && !ld_n) |=> cnt == $past(din));

    assert_step_R3: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && ld_n && en_par && en_trk) |=> cnt == WIDTH'($past(cnt) + 1'b1));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && ld_n && en_par && en_trk && cnt == ALL_ONES) |=> cnt == '0);

    assert_keep_R5: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && ld_n && !(en_par && en_trk)) |=> $stable(cnt));

    assert_tc_gate_R6: assert property (@(posedge clk) disable iff (!armed_q)
        tc |-> (en_trk && cnt == ALL_ONES));

    assert_tc_load_R8: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && !ld_n && din == ALL_ONES) ##1 en_trk |-> tc);
endmodule

// File: tb/sim_presettable_counter.sv
module sim_presettable_counter;
    localparam int W = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int errors = 0;

    logic         clr_n, ld_n, en_par, en_trk;
    logic [W-1:0] din;
    logic [W-1:0] cnt;
    logic         tc;

    presettable_counter #(.WIDTH(W)) u0 (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
        .en_par(en_par), .en_trk(en_trk), .cnt(cnt), .tc(tc)
    );

    // Two-stage lookahead chain for R10.
    logic         c_clr_n, c_en;
    logic [W-1:0] lo_cnt, hi_cnt;
    logic         lo_tc, hi_tc;

    presettable_counter #(.WIDTH(W)) u1 (
        .clk(clk), .clr_n(c_clr_n), .ld_n(1'b1), .din('0),
        .en_par(c_en), .en_trk(c_en), .cnt(lo_cnt), .tc(lo_tc)
    );
    presettable_counter #(.WIDTH(W)) u2 (
        .clk(clk), .clr_n(c_clr_n), .ld_n(1'b1), .din('0),
        .en_par(lo_tc), .en_trk(c_en), .cnt(hi_cnt), .tc(hi_tc)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic l, input logic [W-1:0] d,
                         input logic p, input logic t);
        clr_n = c; ld_n = l; din = d; en_par = p; en_trk = t;
    endtask

    // One rising edge, then settle away from the edge.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic t_clear();
        drive(1'b0, 1'b0, 4'd9, 1'b1, 1'b1);
        tick();
        chk("R1 clear beats load and count", int'(cnt), 0);
        drive(1'b0, 1'b1, 4'd0, 1'b1, 1'b1);
        tick();
        chk("R1 clear beats count", int'(cnt), 0);
    endtask

    task automatic t_load();
        drive(1'b1, 1'b0, 4'd11, 1'b1, 1'b1);
        tick();
        chk("R2 load with enables high", int'(cnt), 11);
        drive(1'b1, 1'b0, 4'd4, 1'b0, 1'b0);
        tick();
        chk("R2 load with enables low", int'(cnt), 4);
    endtask

    task automatic t_count_wrap();
        drive(1'b1, 1'b0, 4'd13, 1'b0, 1'b0);
        tick();
        drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b1);
        tick();
        chk("R3 step 13 to 14", int'(cnt), 14);
        tick();
        chk("R3 step 14 to 15", int'(cnt), 15);
        tick();
        chk("R4 wrap 15 to 0", int'(cnt), 0);
        tick();
        chk("R3 step after wrap", int'(cnt), 1);
    endtask

    task automatic t_hold();
        drive(1'b1, 1'b0, 4'd6, 1'b0, 1'b0);
        tick();
        drive(1'b1, 1'b1, 4'd0, 1'b0, 1'b1);
        tick();
        chk("R5 hold with parallel enable low", int'(cnt), 6);
        drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b0);
        tick();
        chk("R5 hold with trickle enable low", int'(cnt), 6);
    endtask

    task automatic t_tc();
        drive(1'b1, 1'b0, 4'd15, 1'b0, 1'b1);
        tick();
        chk("R8 tc high after loading all ones", int'(tc), 1);
        en_par = 1'b1; #1;
        chk("R6 tc ignores parallel enable", int'(tc), 1);
        en_par = 1'b0;
        en_trk = 1'b0; #1;
        chk("R7 tc drops with trickle enable in same cycle", int'(tc), 0);
        en_trk = 1'b1; #1;
        chk("R7 tc rises with trickle enable in same cycle", int'(tc), 1);
        drive(1'b1, 1'b0, 4'd14, 1'b0, 1'b1);
        tick();
        chk("R6 tc low when not all ones", int'(tc), 0);
    endtask

    task automatic t_between_edges();
        drive(1'b1, 1'b0, 4'd2, 1'b0, 1'b0);
        tick();
        drive(1'b1, 1'b1, 4'd0, 1'b0, 1'b0);
        ld_n = 1'b0; din = 4'd9; #1; ld_n = 1'b1; #1;
        clr_n = 1'b0; #1; clr_n = 1'b1;
        tick();
        chk("R9 pulses between edges ignored", int'(cnt), 2);
    endtask

    task automatic t_cascade();
        c_clr_n = 1'b0; c_en = 1'b0;
        tick();
        chk("R10 chain cleared", int'({hi_cnt, lo_cnt}), 0);
        c_clr_n = 1'b1; c_en = 1'b1;
        for (int i = 1; i <= 256; i++) begin
            tick();
            chk("R10 chained count", int'({hi_cnt, lo_cnt}), i % 256);
            if (i == 255) chk("R10 upper tc at 255", int'(hi_tc), 1);
        end
        c_en = 1'b0;
    endtask

    initial begin
        drive(1'b1, 1'b1, '0, 1'b0, 1'b0);
        c_clr_n = 1'b1; c_en = 1'b0;
        #2;
        t_clear();
        t_load();
        t_count_wrap();
        t_hold();
        t_tc();
        t_between_edges();
        t_cascade();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 5000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule